// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register file of an interrupt router. Software reaches it through two offsets on a simple register bus: an 8-bit select register and a 32-bit data window. The select value chooses what the window shows: an identification register, a version register, an arbitration register, or one 32-bit half of a 64-bit redirection entry. There is one entry per interrupt pin. Reads are combinational; writes take effect at the clock edge on which `bus_wr` is high.

Each entry's routing fields (vector, delivery mode, destination mode, trigger mode, mask, destination) are driven to the delivery logic continuously. The delivery logic owns two fields of every entry: remote-IRR, through set and clear strobes, and delivery status, as a level input. Window writes cannot alter either field. After each table write the block emits two one-cycle events: a service request when the written entry is level-triggered and its pin's request line is high, and a mask-change event when the write flipped the mask bit.

The block is a flat register file; it has no control sequencer. Its ordering rules are:
- Within an entry, a window write that leaves the entry edge-triggered clears remote-IRR, whatever the strobes do in that cycle.
- Otherwise a remote-IRR clear strobe wins over a set strobe.
- Select values from 0x03 to 0x0F, and table indices at or above the pin count, address nothing.

Top module: `irq_redir_window`

## Requirements
- R1: A write to bus offset 0x00 loads the select register with bits 7:0 of the write data. A read at 0x00 returns the select value zero-extended to 32 bits.
- R2: With select 0x01, a window read returns the pin count minus one in bits 23:16, the `VERSION` parameter in bits 7:0, and zero elsewhere. Window writes with this select change nothing.
- R3: With select 0x00, a window write stores data bits 27:24 as a 4-bit identifier. Select 0x00 and select 0x02 both read the identifier in bits 27:24 with all other bits zero. Window writes with select 0x02 are ignored.
- R4: A select value s of 0x10 or above addresses entry (s-0x10)>>1, the lower 32 bits when s is even and the upper 32 bits when s is odd. The entry fields are:
  - vector: bits 7:0
  - delivery mode: bits 10:8
  - destination mode: bit 11
  - delivery status: bit 12
  - polarity: bit 13
  - remote-IRR: bit 14
  - trigger mode: bit 15 (1 = level)
  - mask: bit 16 (1 = masked)
  - destination: bits 63:56

  The per-pin outputs follow the stored entry.
- R5: A window read with select 0x03–0x0F, or with an entry index at or above the pin count, returns 0xFFFFFFFF. A window write there changes no register.
- R6: A window write to one half of an entry leaves the other half unchanged.
- R7: Window writes never change the remote-IRR bit (bit 14) or the delivery-status bit (bit 12). Bit 12 always reads the pin's `dstat_in` line.
- R8: A window write that leaves an entry edge-triggered clears its remote-IRR bit in the same edge. Otherwise `rirr_clr` clears the bit, and `rirr_set` sets it when `rirr_clr` is low.
- R9: A table write that leaves the entry level-triggered while that pin's `pin_req` is high raises `svc_valid` with `svc_pin` for exactly the next cycle. No other write raises it.
- R10: A table write that changes an entry's mask bit raises `mchg_valid` for the next cycle, with `mchg_pin` and the new mask in `mchg_mask`.
- R11: After reset every entry reads 0x00010000 (lower) and 0 (upper), so every mask is set. The select register and identifier are zero.
- R12: Reads at any bus offset other than 0x00 and 0x10 return zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_req | input | PINS | Per-pin pending request lines |
| dstat_in | input | PINS | Per-pin delivery-status level |
| rirr_set | input | PINS | Per-pin remote-IRR set strobe |
| rirr_clr | input | PINS | Per-pin remote-IRR clear strobe |
| ent_vector | output | PINS*8 | Vector field of each entry |
| ent_dlvmode | output | PINS*3 | Delivery-mode field of each entry |
| ent_destmode | output | PINS | Destination-mode bit of each entry |
| ent_level | output | PINS | Trigger-mode bit (1 = level) |
| ent_mask | output | PINS | Mask bit |
| ent_dest | output | PINS*8 | Destination field |
| ent_rirr | output | PINS | Remote-IRR bit |
| svc_valid | output | 1 | One-cycle service request |
| svc_pin | output | IDX_W | Pin of the service request |
| mchg_valid | output | 1 | One-cycle mask-change event |
| mchg_pin | output | IDX_W | Pin whose mask changed |
| mchg_mask | output | 1 | New mask value |

## Verification
The hardest case to reach is a window write that lands on an entry whose remote-IRR bit was set by the delivery side. It needs three steps in order: a level entry, a set strobe, and then a write with the right select parity. In that case edge-trigger clearing, read-only preservation and the service request all interact. Directed sequences drive the set and clear strobes around writes to both halves. Seeded random selects (covering valid, reserved and out-of-range values), random data and random request lines then run against a bench model that predicts every read and every event pulse.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int WORD_W  = 32;
    localparam int ENTRY_W = 64;
    localparam int SEL_W   = 8;

    // entry field positions (decoded by software and delivery logic)
    localparam int VEC_LSB    = 0;
    localparam int VEC_W      = 8;
    localparam int DLV_LSB    = 8;
    localparam int DLV_W      = 3;
    localparam int DSTM_BIT   = 11;
    localparam int DSTAT_BIT  = 12;
    localparam int RIRR_BIT   = 14;
    localparam int TRIG_BIT   = 15;
    localparam int MASK_BIT   = 16;
    localparam int DEST_LSB   = 56;
    localparam int DEST_W     = 8;

    // select codes
    localparam logic [SEL_W-1:0] SEL_IDENT = 8'h00;
    localparam logic [SEL_W-1:0] SEL_VERS  = 8'h01;
    localparam logic [SEL_W-1:0] SEL_ARBIT = 8'h02;
    localparam logic [SEL_W-1:0] SEL_TABLE = 8'h10;

    localparam logic [WORD_W-1:0] LO_RESET = 32'h0001_0000;
    localparam logic [WORD_W-1:0] RO_MASK  = (32'h1 << RIRR_BIT) | (32'h1 << DSTAT_BIT);

    typedef enum logic [2:0] {
        TGT_IDENT,
        TGT_VERS,
        TGT_ARBIT,
        TGT_TABLE,
        TGT_VOID
    } tgt_e;

endpackage

// File: rtl/irw_select.sv
module irw_select
    import irw_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] load_val,
    output logic [SEL_W-1:0] sel_q,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] idx,
    output logic             upper
);

    logic [SEL_W-2:0] idx_full;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (load)
            sel_q <= load_val;
    end

    always_comb begin
        idx_full = 7'((sel_q - SEL_TABLE) >> 1);
        idx      = idx_full[IDX_W-1:0];
        upper    = sel_q[0];
        if (sel_q == SEL_IDENT)
            tgt = TGT_IDENT;
        else if (sel_q == SEL_VERS)
            tgt = TGT_VERS;
        else if (sel_q == SEL_ARBIT)
            tgt = TGT_ARBIT;
        else if (sel_q >= SEL_TABLE && int'(idx_full) < PINS)
            tgt = TGT_TABLE;
        else
            tgt = TGT_VOID;
    end

    // R1 / R12: select changes only on a select-offset write
    p_sel_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> sel_q == $past(sel_q));
    p_sel_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sel_q == $past(load_val));

endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               dstat,
    input  logic               rirr_set,
    input  logic               rirr_clr,
    output logic [ENTRY_W-1:0] entry
);

    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic              rirr_q;
    logic              wr_any;
    logic              lvl_next;

    assign wr_any   = wr_lo | wr_hi;
    assign lvl_next = wr_lo ? wdata[TRIG_BIT] : lo_q[TRIG_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= LO_RESET;
            hi_q <= '0;
        end else begin
            if (wr_lo)
                lo_q <= wdata & ~RO_MASK;
            if (wr_hi)
                hi_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rirr_q <= 1'b0;
        else if (wr_any && !lvl_next)
            rirr_q <= 1'b0;
        else if (rirr_clr)
            rirr_q <= 1'b0;
        else if (rirr_set)
            rirr_q <= 1'b1;
    end

    assign entry = {hi_q, lo_q | (32'(rirr_q) << RIRR_BIT) | (32'(dstat) << DSTAT_BIT)};

    p_half_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> hi_q == $past(hi_q));
    p_edge_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> (lo_q[TRIG_BIT] || !rirr_q));
    p_write_never_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !rirr_set) |=> !$rose(rirr_q));

endmodule

// File: rtl/irw_event.sv
module irw_event #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_fire,
    input  logic             mask_fire,
    input  logic [IDX_W-1:0] pin,
    input  logic             mask_new,
    output logic             svc_valid,
    output logic [IDX_W-1:0] svc_pin,
    output logic             mchg_valid,
    output logic [IDX_W-1:0] mchg_pin,
    output logic             mchg_mask
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_valid  <= 1'b0;
            svc_pin    <= '0;
            mchg_valid <= 1'b0;
            mchg_pin   <= '0;
            mchg_mask  <= 1'b0;
        end else begin
            svc_valid  <= svc_fire;
            mchg_valid <= mask_fire;
            if (svc_fire)
                svc_pin <= pin;
            if (mask_fire) begin
                mchg_pin  <= pin;
                mchg_mask <= mask_new;
            end
        end
    end

endmodule

// File: rtl/irq_redir_window.sv
module irq_redir_window
    import irw_pkg::*;
#(
    parameter int               PINS    = 24,
    parameter logic [7:0]       VERSION = 8'h11,
    parameter logic [7:0]       SEL_OFF = 8'h00,
    parameter logic [7:0]       WIN_OFF = 8'h10,
    localparam int              IDX_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PINS-1:0]      pin_req,
    input  logic [PINS-1:0]      dstat_in,
    input  logic [PINS-1:0]      rirr_set,
    input  logic [PINS-1:0]      rirr_clr,
    output logic [PINS*8-1:0]    ent_vector,
    output logic [PINS*3-1:0]    ent_dlvmode,
    output logic [PINS-1:0]      ent_destmode,
    output logic [PINS-1:0]      ent_level,
    output logic [PINS-1:0]      ent_mask,
    output logic [PINS*8-1:0]    ent_dest,
    output logic [PINS-1:0]      ent_rirr,
    output logic                 svc_valid,
    output logic [IDX_W-1:0]     svc_pin,
    output logic                 mchg_valid,
    output logic [IDX_W-1:0]     mchg_pin,
    output logic                 mchg_mask
);

    localparam logic [7:0] LAST_PIN = 8'(PINS - 1);

    logic [SEL_W-1:0]   sel_q;
    tgt_e               tgt;
    logic [IDX_W-1:0]   idx;
    logic               upper;
    logic               sel_wr;
    logic               win_wr;
    logic               tbl_wr;
    logic [3:0]         ident_q;
    logic [ENTRY_W-1:0] ent_w [PINS];
    logic               old_mask;
    logic               new_mask;
    logic               new_lvl;
    logic               svc_fire;
    logic               mask_fire;

    assign sel_wr = bus_wr && (bus_addr == SEL_OFF);
    assign win_wr = bus_wr && (bus_addr == WIN_OFF);
    assign tbl_wr = win_wr && (tgt == TGT_TABLE);

    irw_select #(.PINS(PINS), .IDX_W(IDX_W)) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel_wr),
        .load_val (bus_wdata[SEL_W-1:0]),
        .sel_q    (sel_q),
        .tgt      (tgt),
        .idx      (idx),
        .upper    (upper)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ident_q <= '0;
        else if (win_wr && tgt == TGT_IDENT)
            ident_q <= bus_wdata[27:24];
    end

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic hit;
        assign hit = tbl_wr && (idx == IDX_W'(g));

        irw_entry u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit && !upper),
            .wr_hi    (hit && upper),
            .wdata    (bus_wdata),
            .dstat    (dstat_in[g]),
            .rirr_set (rirr_set[g]),
            .rirr_clr (rirr_clr[g]),
            .entry    (ent_w[g])
        );

        assign ent_vector[g*8 +: 8]  = ent_w[g][VEC_LSB +: VEC_W];
        assign ent_dlvmode[g*3 +: 3] = ent_w[g][DLV_LSB +: DLV_W];
        assign ent_destmode[g]       = ent_w[g][DSTM_BIT];
        assign ent_level[g]          = ent_w[g][TRIG_BIT];
        assign ent_mask[g]           = ent_w[g][MASK_BIT];
        assign ent_dest[g*8 +: 8]    = ent_w[g][DEST_LSB +: DEST_W];
        assign ent_rirr[g]           = ent_w[g][RIRR_BIT];
    end

    // post-write event evaluation on the entry as it will be after the edge
    always_comb begin
        old_mask  = ent_w[idx][MASK_BIT];
        new_mask  = upper ? old_mask : bus_wdata[MASK_BIT];
        new_lvl   = upper ? ent_w[idx][TRIG_BIT] : bus_wdata[TRIG_BIT];
        svc_fire  = tbl_wr && new_lvl && pin_req[idx];
        mask_fire = tbl_wr && (new_mask != old_mask);
    end

    irw_event #(.IDX_W(IDX_W)) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_fire   (svc_fire),
        .mask_fire  (mask_fire),
        .pin        (idx),
        .mask_new   (new_mask),
        .svc_valid  (svc_valid),
        .svc_pin    (svc_pin),
        .mchg_valid (mchg_valid),
        .mchg_pin   (mchg_pin),
        .mchg_mask  (mchg_mask)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == SEL_OFF) begin
            bus_rdata = {24'h0, sel_q};
        end else if (bus_addr == WIN_OFF) begin
            unique case (tgt)
                TGT_IDENT, TGT_ARBIT: bus_rdata = {4'h0, ident_q, 24'h0};
                TGT_VERS:             bus_rdata = {8'h00, LAST_PIN, 8'h00, VERSION};
                TGT_TABLE:            bus_rdata = upper ? ent_w[idx][63:32] : ent_w[idx][31:0];
                TGT_VOID:             bus_rdata = '1;
                default:              bus_rdata = '1;
            endcase
        end
    end

    p_arb_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && tgt != TGT_IDENT) |=> ident_q == $past(ident_q));
    p_void_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && tgt == TGT_VOID && rirr_set == '0 && rirr_clr == '0)
            |=> (ent_mask == $past(ent_mask) && ent_level == $past(ent_level)
                 && ent_rirr == $past(ent_rirr)));
    p_svc_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> ent_level[svc_pin]);
    p_svc_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> $past(win_wr));
    p_mchg_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> ent_mask[mchg_pin] == mchg_mask);

endmodule

// File: tb/test_irq_redir_window.sv
module test_irq_redir_window;

    localparam int NP = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_req = '0;
    logic [NP-1:0]     dstat_in = '0;
    logic [NP-1:0]     rirr_set = '0;
    logic [NP-1:0]     rirr_clr = '0;
    logic [NP*8-1:0]   ent_vector;
    logic [NP*3-1:0]   ent_dlvmode;
    logic [NP-1:0]     ent_destmode;
    logic [NP-1:0]     ent_level;
    logic [NP-1:0]     ent_mask;
    logic [NP*8-1:0]   ent_dest;
    logic [NP-1:0]     ent_rirr;
    logic              svc_valid;
    logic [4:0]        svc_pin;
    logic              mchg_valid;
    logic [4:0]        mchg_pin;
    logic              mchg_mask;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [31:0] m_lo [NP];
    logic [31:0] m_hi [NP];
    logic [NP-1:0] m_rirr;

    always #2 clk = ~clk;

    irq_redir_window i_irq_redir_window (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_req(pin_req),
        .dstat_in(dstat_in), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
        .ent_vector(ent_vector), .ent_dlvmode(ent_dlvmode),
        .ent_destmode(ent_destmode), .ent_level(ent_level), .ent_mask(ent_mask),
        .ent_dest(ent_dest), .ent_rirr(ent_rirr), .svc_valid(svc_valid),
        .svc_pin(svc_pin), .mchg_valid(mchg_valid), .mchg_pin(mchg_pin),
        .mchg_mask(mchg_mask)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int tbl_index(input logic [7:0] s);
        int ix;
        if (s < 8'h10) return -1;
        ix = (int'(s) - 16) >> 1;
        if (ix >= NP) return -1;
        return ix;
    endfunction

    function automatic logic [31:0] exp_win(input logic [7:0] s);
        int ix;
        if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
        if (s == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
        ix = tbl_index(s);
        if (ix < 0) return 32'hFFFF_FFFF;
        if (s[0]) return m_hi[ix];
        return m_lo[ix] | (32'(m_rirr[ix]) << 14) | (32'(dstat_in[ix]) << 12);
    endfunction

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic sel_set(input logic [7:0] s);
        m_sel = s;
        bw(8'h00, {$urandom} & 32'hFFFF_FF00 | 32'(s));
    endtask

    // window write with model update and event checks
    task automatic win_put(input logic [31:0] d);
        int  ix;
        logic nlvl, om, nm, e_svc, e_m;
        ix = tbl_index(m_sel);
        e_svc = 1'b0;
        e_m = 1'b0;
        nm = 1'b0;
        if (m_sel == 8'h00) m_id = d[27:24];
        if (ix >= 0) begin
            nlvl  = m_sel[0] ? m_lo[ix][15] : d[15];
            om    = m_lo[ix][16];
            nm    = m_sel[0] ? om : d[16];
            e_svc = nlvl && pin_req[ix];
            e_m   = (om != nm);
            if (m_sel[0]) m_hi[ix] = d;
            else          m_lo[ix] = d & ~32'h0000_5000;
            if (!nlvl) m_rirr[ix] = 1'b0;
        end
        bw(8'h10, d);
        chk("R9 svc_valid", 64'(svc_valid), 64'(e_svc));
        if (e_svc) chk("R9 svc_pin", 64'(svc_pin), 64'(ix));
        chk("R10 mchg_valid", 64'(mchg_valid), 64'(e_m));
        if (e_m) begin
            chk("R10 mchg_pin", 64'(mchg_pin), 64'(ix));
            chk("R10 mchg_mask", 64'(mchg_mask), 64'(nm));
        end
    endtask

    task automatic chk_fields(input int ix);
        chk("R4 vector",   64'(ent_vector[ix*8 +: 8]), 64'(m_lo[ix][7:0]));
        chk("R4 dlvmode",  64'(ent_dlvmode[ix*3 +: 3]), 64'(m_lo[ix][10:8]));
        chk("R4 destmode", 64'(ent_destmode[ix]), 64'(m_lo[ix][11]));
        chk("R4 level",    64'(ent_level[ix]), 64'(m_lo[ix][15]));
        chk("R4 mask",     64'(ent_mask[ix]), 64'(m_lo[ix][16]));
        chk("R4 dest",     64'(ent_dest[ix*8 +: 8]), 64'(m_hi[ix][31:24]));
        chk("R8 rirr",     64'(ent_rirr[ix]), 64'(m_rirr[ix]));
    endtask

    task automatic read_win(input string req);
        logic [31:0] d;
        br(8'h10, d);
        chk(req, 64'(d), 64'(exp_win(m_sel)));
    endtask

    task automatic pulse_rirr(input int ix, input logic s, input logic c);
        rirr_set[ix] = s;
        rirr_clr[ix] = c;
        @(negedge clk);
        rirr_set[ix] = 1'b0;
        rirr_clr[ix] = 1'b0;
        if (c) m_rirr[ix] = 1'b0;
        else if (s) m_rirr[ix] = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        m_sel = '0;
        m_id = '0;
        m_rirr = '0;
        for (int i = 0; i < NP; i++) begin
            m_lo[i] = 32'h0001_0000;
            m_hi[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        br(8'h00, d);
        chk("R11 select reset", 64'(d), 64'h0);
        chk("R11 masks set", 64'(ent_mask), 64'({NP{1'b1}}));
        read_win("R11 ident reset");
        sel_set(8'h10);
        br(8'h10, d);
        chk("R11 entry lo reset", 64'(d), 64'h0001_0000);

        // R1 select low byte
        bw(8'h00, 32'h1234_56AB);
        m_sel = 8'hAB;
        br(8'h00, d);
        chk("R1 select readback", 64'(d), 64'h0000_00AB);

        // R2 version and ignored write
        sel_set(8'h01);
        br(8'h10, d);
        chk("R2 version", 64'(d), 64'h0017_0011);
        win_put(32'hFFFF_FFFF);
        br(8'h10, d);
        chk("R2 version after write", 64'(d), 64'h0017_0011);

        // R3 identifier and arbitration
        sel_set(8'h00);
        win_put(32'hFA00_0000);
        br(8'h10, d);
        chk("R3 ident", 64'(d), 64'h0A00_0000);
        sel_set(8'h02);
        br(8'h10, d);
        chk("R3 arb reads ident", 64'(d), 64'h0A00_0000);
        win_put(32'h0500_0000);
        sel_set(8'h00);
        br(8'h10, d);
        chk("R3 arb write ignored", 64'(d), 64'h0A00_0000);

        // R4 table fields on pin 3
        sel_set(8'h16);
        win_put(32'h0000_8035);
        br(8'h10, d);
        chk("R4 lo readback", 64'(d), 64'h0000_8035);
        sel_set(8'h17);
        win_put(32'hC100_0000);
        read_win("R4 hi readback");
        chk_fields(3);

        // R6 writing the lower half keeps the upper one
        sel_set(8'h16);
        win_put(32'h0000_8136);
        sel_set(8'h17);
        br(8'h10, d);
        chk("R6 hi kept", 64'(d), 64'hC100_0000);

        // R5 out of range
        sel_set(8'h40);
        br(8'h10, d);
        chk("R5 idx 24 all ones", 64'(d), 64'hFFFF_FFFF);
        win_put(32'h0000_0000);
        chk("R5 masks unchanged", 64'(ent_mask), 64'({NP{1'b1}} & ~(64'h1 << 3)));
        sel_set(8'h05);
        read_win("R5 reserved select");
        sel_set(8'h3F);
        read_win("R5 last pin upper");

        // R7 read-only bits
        dstat_in[5] = 1'b1;
        sel_set(8'h1A);
        win_put(32'h0001_4022);
        br(8'h10, d);
        chk("R7 ro bits", 64'(d), 64'h0001_1022);
        chk("R7 rirr not written", 64'(ent_rirr[5]), 64'h0);

        // R8 remote-IRR behaviour on pin 3 (level)
        pulse_rirr(3, 1'b1, 1'b0);
        chk("R8 set", 64'(ent_rirr[3]), 64'h1);
        sel_set(8'h17);
        win_put(32'hC200_0000);
        chk("R8 hi write keeps rirr", 64'(ent_rirr[3]), 64'h1);
        sel_set(8'h16);
        read_win("R8 rirr visible");
        pulse_rirr(3, 1'b1, 1'b1);
        chk("R8 clear priority", 64'(ent_rirr[3]), 64'h0);
        pulse_rirr(3, 1'b1, 1'b0);
        win_put(32'h0000_0035);
        chk("R8 edge write clears", 64'(ent_rirr[3]), 64'h0);
        read_win("R8 edge readback");

        // R9 service request
        pin_req[3] = 1'b1;
        win_put(32'h0000_8035);
        @(negedge clk);
        chk("R9 one cycle", 64'(svc_valid), 64'h0);
        win_put(32'h0000_0035);
        pin_req[3] = 1'b0;

        // R10 mask change
        sel_set(8'h1E);
        win_put(32'h0000_0040);
        win_put(32'h0000_0040);
        win_put(32'h0001_0040);

        // R12 other offsets
        bw(8'h20, 32'h0000_00FF);
        br(8'h00, d);
        chk("R12 select untouched", 64'(d), 64'(m_sel));
        br(8'h20, d);
        chk("R12 other read", 64'(d), 64'h0);
        br(8'h04, d);
        chk("R12 other read 04", 64'(d), 64'h0);

        // constrained random phase
        dstat_in = NP'($urandom);
        for (int it = 0; it < 800; it++) begin
            int op;
            op = int'($urandom % 8);
            pin_req = NP'($urandom);
            if (op < 2) begin
                if (($urandom % 4) == 0) sel_set(8'($urandom));
                else sel_set(8'($urandom % 8'h44));
            end else if (op < 5) begin
                win_put($urandom);
                if (tbl_index(m_sel) >= 0) chk_fields(tbl_index(m_sel));
            end else if (op < 7) begin
                read_win("R4 random window read");
            end else begin
                logic [7:0] a;
                a = 8'($urandom);
                if (a == 8'h00 || a == 8'h10) a = 8'h30;
                bw(a, $urandom);
                br(a, d);
                chk("R12 random other offset", 64'(d), 64'h0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule